// File: doc/BRIEF.md
# Cartridge Bank-Switching Address Translator

This block sits between a console's CPU and PPU buses and the wide program and pattern ROMs on a cartridge. The CPU programs it through writes to the top half of its address space. One register holds the mode and chooses the target. Eight bank registers hold bank numbers. From these, the block turns every CPU program address and every PPU pattern address into a ROM address.

The program side divides $8000-$FFFF into four 8 KB windows. Two of them follow bank registers. One is fixed to the second-last bank and one to the last bank. A mode bit exchanges the first and third windows. The pattern side divides the 8 KB pattern space into a half that holds two 2 KB banks and a half that holds four 1 KB banks. A second mode bit exchanges the two halves. Translation is combinational. A register write therefore affects translation from the cycle after the write edge.

Top module: `cart_bank_xlate`

## Requirements
- R1: On synchronous active-high reset, the select register and all eight bank registers become zero. After reset, $8000 and $A000 map to bank 0, $C000 maps to bank PRG_BANKS-2 and $E000 maps to bank PRG_BANKS-1.
- R2: A write with cpu_addr[15:13]=3'b100 and cpu_addr[0]=0 loads cpu_data into the select register. Bit 7 of that register is the pattern swap, bit 6 is the program swap, and bits 2:0 name the bank register for data writes.
- R3: A write with cpu_addr[15:13]=3'b100 and cpu_addr[0]=1 loads cpu_data into the bank register named by select bits 2:0. Address bits 12:1 are not decoded, so $9FFE and $9FFF act the same as $8000 and $8001.
- R4: Writes with cpu_addr[15:13] other than 3'b100 change no register. This covers addresses below $8000 and the pairs at $A000-$FFFF.
- R5: With program swap 0, $8000-$9FFF maps to the bank in register 6 and $C000-$DFFF maps to bank PRG_BANKS-2.
- R6: With program swap 1, $8000-$9FFF maps to bank PRG_BANKS-2 and $C000-$DFFF maps to the bank in register 6.
- R7: $A000-$BFFF always maps to the bank in register 7, and $E000-$FFFF always maps to bank PRG_BANKS-1, whatever the mode.
- R8: With pattern swap 0, PPU $0000-$07FF and $0800-$0FFF use registers 0 and 1 as 2 KB banks. The low bit of these registers is ignored and replaced by ppu_addr[10]. PPU $1000-$1FFF uses registers 2 to 5 as 1 KB banks, chosen by ppu_addr[11:10].
- R9: With pattern swap 1, the 1 KB banks from registers 2 to 5 occupy $0000-$0FFF and the 2 KB banks from registers 0 and 1 occupy $1000-$1FFF.
- R10: prg_addr is {bank, cpu_addr[12:0]} and chr_addr is {bank, ppu_addr[9:0]}. A program bank register keeps only its low log2(PRG_BANKS) bits, so bits 7:6 are dropped by default.
- R11: A register write is visible in the translation during the cycle right after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address, used for decode and program translation |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, sampled on the rising edge |
| ppu_addr | input | 13 | PPU pattern address |
| prg_addr | output | 19 | Program ROM address (log2(PRG_BANKS)+13 bits) |
| chr_addr | output | 18 | Pattern ROM address (CHR_BANK_W+10 bits) |

## Verification
A wrong select register shows up one cycle after the write in two ways. It moves the fixed second-last bank into the other window, or it moves the 2 KB and 1 KB halves of the pattern space. A data write that lands in the wrong register shows up as a wrong bank in the window that register feeds, as soon as that window is looked up. A decode that also accepts the $A000-$FFFF pairs is exposed when a following program lookup returns a changed mode or a changed register 6. The bench mixes random writes with lookups across all four program windows and all eight 1 KB pattern slots. Any such error is therefore caught within one lookup sweep of the write that caused it.

// File: rtl/bankx_pkg.sv
package bankx_pkg;

    localparam int REG_COUNT = 8;
    localparam int REG_IDX_W = $clog2(REG_COUNT);
    localparam int PRG_OFF_W = 13;
    localparam int CHR_OFF_W = 10;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        WR_NONE = 2'd0,
        WR_SEL  = 2'd1,
        WR_DATA = 2'd2
    } wr_kind_t;

    typedef enum logic [1:0] {
        WIN_LO  = 2'd0,
        WIN_MID = 2'd1,
        WIN_HI  = 2'd2,
        WIN_TOP = 2'd3
    } prg_win_t;

    typedef struct packed {
        logic                 chr_swap;
        logic                 prg_swap;
        logic [REG_IDX_W-1:0] target;
    } sel_t;

    function automatic wr_kind_t classify_write(input logic [15:0] addr, input logic wr);
        if (!wr || addr[15:13] != 3'b100) return WR_NONE;
        return addr[0] ? WR_DATA : WR_SEL;
    endfunction

    function automatic sel_t unpack_sel(input byte_t raw);
        sel_t s;
        s.chr_swap = raw[7];
        s.prg_swap = raw[6];
        s.target   = raw[REG_IDX_W-1:0];
        return s;
    endfunction

endpackage

// File: rtl/bankx_regfile.sv
module bankx_regfile
    import bankx_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [15:0]            cpu_addr,
    input  logic [7:0]             cpu_data,
    input  logic                   cpu_wr,
    output logic [7:0]             sel_q,
    output logic [REG_COUNT*8-1:0] regs_flat
);
    wr_kind_t kind;
    sel_t     sel_f;

    always_comb begin
        kind  = classify_write(cpu_addr, cpu_wr);
        sel_f = unpack_sel(sel_q);
    end

    always_ff @(posedge clk) begin
        if (rst)                 sel_q <= '0;
        else if (kind == WR_SEL) sel_q <= cpu_data;
    end

    for (genvar i = 0; i < REG_COUNT; i++) begin : g_bank
        logic [7:0] value_q;
        always_ff @(posedge clk) begin
            if (rst)
                value_q <= '0;
            else if (kind == WR_DATA && sel_f.target == REG_IDX_W'(i))
                value_q <= cpu_data;
        end
        assign regs_flat[i*8 +: 8] = value_q;
    end
endmodule

// File: rtl/bankx_prg_map.sv
module bankx_prg_map
    import bankx_pkg::*;
#(
    parameter int PRG_BANKS = 64,
    localparam int BANK_W   = $clog2(PRG_BANKS),
    localparam int AW       = BANK_W + PRG_OFF_W
) (
    input  logic [15:0]  cpu_addr,
    input  logic         prg_swap,
    input  logic [7:0]   reg6,
    input  logic [7:0]   reg7,
    output logic [AW-1:0] prg_addr
);
    localparam logic [BANK_W-1:0] LAST_BANK   = BANK_W'(PRG_BANKS - 1);
    localparam logic [BANK_W-1:0] SECOND_LAST = BANK_W'(PRG_BANKS - 2);

    prg_win_t          win;
    logic [BANK_W-1:0] bank;

    always_comb begin
        win = prg_win_t'(cpu_addr[14:13]);
        unique case (win)
            WIN_LO:  bank = prg_swap ? SECOND_LAST : reg6[BANK_W-1:0];
            WIN_MID: bank = reg7[BANK_W-1:0];
            WIN_HI:  bank = prg_swap ? reg6[BANK_W-1:0] : SECOND_LAST;
            default: bank = LAST_BANK;
        endcase
        prg_addr = {bank, cpu_addr[PRG_OFF_W-1:0]};
    end
endmodule

// File: rtl/bankx_chr_map.sv
module bankx_chr_map
    import bankx_pkg::*;
#(
    parameter int CHR_BANK_W = 8,
    localparam int AW        = CHR_BANK_W + CHR_OFF_W
) (
    input  logic [12:0]   ppu_addr,
    input  logic          chr_swap,
    input  logic [47:0]   chr_regs,
    output logic [AW-1:0] chr_addr
);
    logic                  big_half;
    logic [7:0]            pick;
    logic [CHR_BANK_W-1:0] bank;

    always_comb begin
        big_half = ~(ppu_addr[12] ^ chr_swap);
        if (big_half) begin
            pick = chr_regs[{2'b00, ppu_addr[11]}*8 +: 8];
            bank = {pick[CHR_BANK_W-1:1], ppu_addr[10]};
        end else begin
            pick = chr_regs[(3'd2 + {1'b0, ppu_addr[11:10]})*8 +: 8];
            bank = pick[CHR_BANK_W-1:0];
        end
        chr_addr = {bank, ppu_addr[CHR_OFF_W-1:0]};
    end
endmodule

// File: rtl/cart_bank_xlate.sv
module cart_bank_xlate
    import bankx_pkg::*;
#(
    parameter int PRG_BANKS  = 64,
    parameter int CHR_BANK_W = 8,
    localparam int PRG_AW    = $clog2(PRG_BANKS) + PRG_OFF_W,
    localparam int CHR_AW    = CHR_BANK_W + CHR_OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_data,
    input  logic              cpu_wr,
    input  logic [12:0]       ppu_addr,
    output logic [PRG_AW-1:0] prg_addr,
    output logic [CHR_AW-1:0] chr_addr
);
    logic [7:0]             bank_sel;
    logic [REG_COUNT*8-1:0] regs_flat;
    sel_t                   sel_f;

    assign sel_f = unpack_sel(bank_sel);

    bankx_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .cpu_wr   (cpu_wr),
        .sel_q    (bank_sel),
        .regs_flat(regs_flat)
    );

    bankx_prg_map #(.PRG_BANKS(PRG_BANKS)) u_prg (
        .cpu_addr(cpu_addr),
        .prg_swap(sel_f.prg_swap),
        .reg6    (regs_flat[6*8 +: 8]),
        .reg7    (regs_flat[7*8 +: 8]),
        .prg_addr(prg_addr)
    );

    bankx_chr_map #(.CHR_BANK_W(CHR_BANK_W)) u_chr (
        .ppu_addr(ppu_addr),
        .chr_swap(sel_f.chr_swap),
        .chr_regs(regs_flat[47:0]),
        .chr_addr(chr_addr)
    );
endmodule

// File: rtl/bankx_chk.sv
module bankx_chk #(
    parameter int PRG_BANKS  = 64,
    parameter int PRG_AW     = 19,
    parameter int CHR_AW     = 18
) (
    input logic              clk,
    input logic              rst,
    input logic [15:0]       cpu_addr,
    input logic [7:0]        cpu_data,
    input logic              cpu_wr,
    input logic [12:0]       ppu_addr,
    input logic [PRG_AW-1:0] prg_addr,
    input logic [CHR_AW-1:0] chr_addr,
    input logic [7:0]        bank_sel,
    input logic [63:0]       regs_flat
);
    localparam int BW = PRG_AW - 13;
    localparam logic [BW-1:0] LAST = BW'(PRG_BANKS - 1);
    localparam logic [BW-1:0] SLAST = BW'(PRG_BANKS - 2);

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(cpu_wr && cpu_addr[15:13] == 3'b100) |=> ($stable(bank_sel) && $stable(regs_flat)));

    p_data_store_r3: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[15:13] == 3'b100 && cpu_addr[0])
        |=> regs_flat[$past(bank_sel[2:0])*8 +: 8] == $past(cpu_data));

    p_sel_store_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[15:13] == 3'b100 && !cpu_addr[0]) |=> bank_sel == $past(cpu_data));

    p_c000_fixed_r5: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:13] == 3'b110 && !bank_sel[6]) |-> prg_addr[PRG_AW-1:13] == SLAST);

    p_8000_fixed_r6: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:13] == 3'b100 && bank_sel[6]) |-> prg_addr[PRG_AW-1:13] == SLAST);

    p_last_fixed_r7: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:13] == 3'b111) |-> prg_addr[PRG_AW-1:13] == LAST);

    p_offsets_r10: assert property (@(posedge clk) disable iff (rst)
        (prg_addr[12:0] == cpu_addr[12:0]) && (chr_addr[9:0] == ppu_addr[9:0]));
endmodule

bind cart_bank_xlate bankx_chk #(
    .PRG_BANKS(PRG_BANKS),
    .PRG_AW   (PRG_AW),
    .CHR_AW   (CHR_AW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cpu_addr (cpu_addr),
    .cpu_data (cpu_data),
    .cpu_wr   (cpu_wr),
    .ppu_addr (ppu_addr),
    .prg_addr (prg_addr),
    .chr_addr (chr_addr),
    .bank_sel (bank_sel),
    .regs_flat(regs_flat)
);

// File: tb/tb_cart_bank_xlate.sv
`timescale 1ns/1ps
module tb_cart_bank_xlate;
    localparam int PRG_BANKS = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_wr = 1'b0;
    logic [12:0] ppu_addr = '0;
    logic [18:0] prg_addr;
    logic [17:0] chr_addr;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    logic [7:0] m_sel;
    logic [7:0] m_regs [8];

    always #2.5 clk = ~clk;

    cart_bank_xlate #(.PRG_BANKS(PRG_BANKS), .CHR_BANK_W(8)) dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_addr(prg_addr), .chr_addr(chr_addr)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            failures = failures + 1;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [18:0] exp_prg(input logic [15:0] a);
        logic [5:0] b;
        case (a[14:13])
            2'd0: b = m_sel[6] ? 6'(PRG_BANKS - 2) : m_regs[6][5:0];
            2'd1: b = m_regs[7][5:0];
            2'd2: b = m_sel[6] ? m_regs[6][5:0] : 6'(PRG_BANKS - 2);
            default: b = 6'(PRG_BANKS - 1);
        endcase
        return {b, a[12:0]};
    endfunction

    function automatic logic [17:0] exp_chr(input logic [12:0] p);
        logic [7:0] b;
        if ((p[12] ^ m_sel[7]) == 1'b0) b = {m_regs[p[11]][7:1], p[10]};
        else                            b = m_regs[2 + p[11:10]];
        return {b, p[9:0]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
        if (a[15:13] == 3'b100) begin
            if (a[0]) m_regs[m_sel[2:0]] = d;
            else      m_sel = d;
        end
    endtask

    task automatic look_prg(input string tag, input logic [15:0] a);
        cpu_addr = a; #1;
        check(tag, 32'(prg_addr), 32'(exp_prg(a)));
    endtask

    task automatic look_chr(input string tag, input logic [12:0] p);
        ppu_addr = p; #1;
        check(tag, 32'(chr_addr), 32'(exp_chr(p)));
    endtask

    task automatic sweep(input string tag);
        for (int w = 0; w < 4; w++)
            look_prg(tag, 16'h8000 | 16'(w << 13) | 16'($urandom & 16'h1FFF));
        for (int s = 0; s < 8; s++)
            look_chr(tag, 13'(s << 10) | 13'($urandom & 13'h3FF));
    endtask

    initial begin
        void'($urandom(32'd20240601));
        m_sel = '0;
        for (int i = 0; i < 8; i++) m_regs[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state, including fixed-bank values
        cpu_addr = 16'hC123; #1; check("R1 c000", 32'(prg_addr), {13'd0, 6'd62, 13'h0123});
        cpu_addr = 16'hE000; #1; check("R1 e000", 32'(prg_addr), {13'd0, 6'd63, 13'h0000});
        ppu_addr = 13'h0400; #1; check("R1 chr", 32'(chr_addr), 32'h400);
        sweep("R1");

        // R2 R11 select write and next-cycle visibility
        cpu_write(16'h8000, 8'h46);
        cpu_write(16'h8001, 8'h15);
        sweep("R2 R11");
        cpu_addr = 16'hC000; #1; check("R6 c000 r6", 32'(prg_addr), {13'd0, 6'h15, 13'h0});

        // R3 mirrored decode at $9FFE/$9FFF
        cpu_write(16'h9FFE, 8'h07);
        cpu_write(16'h9FFF, 8'h21);
        cpu_addr = 16'hA010; #1; check("R3 mirror", 32'(prg_addr), {13'd0, 6'h21, 13'h0010});

        // R4 writes outside $8000-$9FFF ignored
        cpu_write(16'h8000, 8'h06);
        cpu_write(16'hA000, 8'hC7);
        cpu_write(16'hA001, 8'h3F);
        cpu_write(16'hC001, 8'h2A);
        cpu_write(16'hE000, 8'hFF);
        cpu_write(16'h7001, 8'h11);
        cpu_write(16'h6000, 8'h80);
        sweep("R4");

        // R5 mode 0
        cpu_write(16'h8001, 8'h0C);
        sweep("R5");
        // R6 mode 1
        cpu_write(16'h8000, 8'h46);
        sweep("R6");
        // R7 fixed last and R7 window
        cpu_write(16'h8000, 8'h07);
        cpu_write(16'h8001, 8'h3E);
        look_prg("R7 a000", 16'hBFFF);
        look_prg("R7 e000", 16'hE555);

        // R10 truncation of program bank bits 7:6
        cpu_write(16'h8000, 8'h06);
        cpu_write(16'h8001, 8'hC5);
        cpu_addr = 16'h8001; #1; check("R10 trunc", 32'(prg_addr), {13'd0, 6'h05, 13'h0001});

        // R8 CHR mode 0, low bit of 2 KB regs ignored
        cpu_write(16'h8000, 8'h00); cpu_write(16'h8001, 8'h0B);
        cpu_write(16'h8000, 8'h01); cpu_write(16'h8001, 8'h20);
        for (int k = 2; k < 6; k++) begin
            cpu_write(16'h8000, 8'(k)); cpu_write(16'h8001, 8'(8'h90 + k));
        end
        ppu_addr = 13'h0000; #1; check("R8 lo", 32'(chr_addr), {14'd0, 8'h0A, 10'h0});
        ppu_addr = 13'h0400; #1; check("R8 hi", 32'(chr_addr), {14'd0, 8'h0B, 10'h0});
        sweep("R8");
        // R9 CHR mode 1
        cpu_write(16'h8000, 8'h80);
        ppu_addr = 13'h1C05; #1; check("R9 top", 32'(chr_addr), {14'd0, 8'h21, 10'h005});
        ppu_addr = 13'h0C00; #1; check("R9 low", 32'(chr_addr), {14'd0, 8'h95, 10'h0});
        sweep("R9");

        // random mix
        for (int n = 0; n < 300; n++) begin
            logic [15:0] a;
            a = 16'($urandom);
            if ($urandom % 3 != 0) a[15:13] = 3'b100;
            cpu_write(a, 8'($urandom));
            look_prg("R5 R6 R7 rand", 16'h8000 | 16'($urandom));
            look_chr("R8 R9 rand", 13'($urandom));
        end

        // R1 reset again after activity
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        m_sel = '0;
        for (int i = 0; i < 8; i++) m_regs[i] = '0;
        sweep("R1 rereset");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule